// File: doc/BRIEF.md
# Dual-Bank FM Synthesizer Register Port

This block is the host side of a six-voice, four-operator FM synthesizer. The host sees four byte addresses, split into two banks. In each bank, one address selects a register number and the other writes a byte to the selected register. Each accepted data write becomes one decoded update on the output side. The update is one of the following:

- a per-operator parameter update, tagged with its voice, operator slot and field;
- a frequency update for one voice;
- an algorithm select;
- a key-on/off event;
- a timer reload value;
- a DAC control change or DAC sample.

The synthesis engine that consumes these strobes is outside this block.

Bank 0 addresses voices 0–2 and bank 1 addresses voices 3–5. The frequency upper bits and block arrive in a separate register. They are held per voice until the matching low-byte write, so a voice only ever receives a complete frequency word. A read from any address returns a status byte built from the two timer overflow flags.

Top module: `fm_regport`

## Requirements
- R1: A write to address 0 (bank 0) or 2 (bank 1) stores the byte as that bank's selected register. A write to address 1 or 3 applies the byte to the selected register of bank 0 or bank 1. A data write is ignored while the bank's selection is 0, and after reset both selections are 0.
- R2: A data write to a register in 0x30..0x9F whose bits 1:0 are not 3 pulses `op_wr`. It reports the following:
  - `op_voice` = bits 1:0 plus 3 for bank 1;
  - `op_slot` = bits 3:2;
  - `op_field` = bits 7:4 minus 3, so 0x3x gives 0 and 0x9x gives 6;
  - `op_value` = the written byte.
- R3: In 0x30..0x9F, a register whose bits 1:0 equal 3 produces no `op_wr` and raises `unhandled`.
- R4: With each `op_wr`, `op_mul_x2` gives twice the multiplier taken from data bits 3:0. A nibble of 0 yields 1 (one half), and a nibble n yields 2n.
- R5: With each `op_wr`, `op_att_qdb` gives the attenuation in quarter-dB units, equal to 3 × data bits 6:0. Bit 7 is ignored.
- R6: The timer A reload value is 10 bits.
  - Register 0x24 sets bits 9:2 of `tmr_a_load`.
  - Register 0x25 sets bits 1:0 from data bits 1:0.
  - Either write pulses `tmr_a_wr`.
  - Register 0x26 sets `tmr_b_load` and pulses `tmr_b_wr`.
  - The loads hold their value otherwise.
- R7: A write to 0x28 pulses `key_wr`, with `key_voice` = data bits 2:0 and `key_mask` = data bits 7:4.
- R8: Register 0x2B sets `dac_en` from data bit 7. A write to 0x2A pulses `dac_wr` with `dac_sample` = data only while `dac_en` is 1. Otherwise the write is dropped without `unhandled`.
- R9: A write to 0xA4..0xA6 stores, for voice (bits 1:0 plus 3 for bank 1), the frequency upper 3 bits from data bits 2:0 and the block from data bits 5:3. It produces no strobe. A write to 0xA0..0xA2 pulses `frq_wr` for that voice, with `frq_num` = {stored upper bits, data} and `frq_block` = stored block. The stored values persist across low-byte writes.
- R10: A write to 0xB0..0xB2 pulses `alg_wr` with `alg_voice` = bits 1:0 plus 3 for bank 1, and `alg_sel` = data bits 2:0.
- R11: `rd_data` always equals {6'b0, `timer_a_ovf`, `timer_b_ovf`}, whatever the address.
- R12: A data write to any other nonzero register raises `unhandled`. This includes 0x27, 0xA3, 0xA7 and 0xB3, and registers below 0x24. Such a write changes neither the timer loads, `dac_en` nor any stored frequency bits.
- R13: Every strobe and `unhandled` is a one-cycle pulse in the cycle after the data-write edge. At most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write enable for one cycle |
| bus_addr | input | 2 | Byte address: bit 1 bank, bit 0 data (1) or select (0) |
| bus_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Status byte |
| timer_a_ovf | input | 1 | Timer A overflow flag |
| timer_b_ovf | input | 1 | Timer B overflow flag |
| op_wr | output | 1 | Operator parameter strobe |
| op_voice | output | 3 | Operator update voice |
| op_slot | output | 2 | Operator slot |
| op_field | output | 3 | Parameter group 0..6 |
| op_value | output | 8 | Raw written byte |
| op_mul_x2 | output | 5 | Doubled multiplier |
| op_att_qdb | output | 9 | Attenuation in quarter dB |
| tmr_a_wr | output | 1 | Timer A reload strobe |
| tmr_a_load | output | 10 | Timer A reload value |
| tmr_b_wr | output | 1 | Timer B reload strobe |
| tmr_b_load | output | 8 | Timer B reload value |
| key_wr | output | 1 | Key event strobe |
| key_voice | output | 3 | Key event voice |
| key_mask | output | 4 | Per-operator key-on flags |
| dac_en | output | 1 | DAC enable |
| dac_wr | output | 1 | DAC sample strobe |
| dac_sample | output | 8 | DAC sample |
| frq_wr | output | 1 | Frequency update strobe |
| frq_voice | output | 3 | Frequency update voice |
| frq_num | output | 11 | Frequency number |
| frq_block | output | 3 | Octave block |
| alg_wr | output | 1 | Algorithm strobe |
| alg_voice | output | 3 | Algorithm voice |
| alg_sel | output | 3 | Algorithm number |
| unhandled | output | 1 | Write to an unimplemented register |

## Verification
Register selections, staged frequency bits and `dac_en` take effect at the write edge. The first data write after a select therefore already uses the new selection.

Every decoded strobe, its fields and `unhandled` are due exactly one cycle after the data-write edge. The bench drives a write on a falling edge and samples at the next falling edge, which lies after the capturing rising edge. One more falling edge later, it confirms the pulse has ended.

The status byte has no register in its path. It is checked in the same cycle the flag inputs change. Dropped and unhandled writes are checked at the ports, by reading back the timer loads, `dac_en` and the frequency words produced by a following low-byte write.

// File: rtl/fm_regport.sv
module fm_regport (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  rd_data,
  input  logic        timer_a_ovf,
  input  logic        timer_b_ovf,
  output logic        op_wr,
  output logic [2:0]  op_voice,
  output logic [1:0]  op_slot,
  output logic [2:0]  op_field,
  output logic [7:0]  op_value,
  output logic [4:0]  op_mul_x2,
  output logic [8:0]  op_att_qdb,
  output logic        tmr_a_wr,
  output logic [9:0]  tmr_a_load,
  output logic        tmr_b_wr,
  output logic [7:0]  tmr_b_load,
  output logic        key_wr,
  output logic [2:0]  key_voice,
  output logic [3:0]  key_mask,
  output logic        dac_en,
  output logic        dac_wr,
  output logic [7:0]  dac_sample,
  output logic        frq_wr,
  output logic [2:0]  frq_voice,
  output logic [10:0] frq_num,
  output logic [2:0]  frq_block,
  output logic        alg_wr,
  output logic [2:0]  alg_voice,
  output logic [2:0]  alg_sel,
  output logic        unhandled
);
  localparam int VPB = 3;
  localparam int NV  = 2 * VPB;

  logic [7:0] sel_q [2];
  logic [5:0] stage_q [NV];

  wire       bank    = bus_addr[1];
  wire [7:0] r       = sel_q[bank];
  wire [7:0] d       = bus_wdata;
  wire       go      = bus_we && bus_addr[0] && (r != 8'h00);
  wire       slot_ok = (r[1:0] != 2'b11);
  wire [2:0] voice   = {1'b0, r[1:0]} + (bank ? 3'(VPB) : 3'd0);

  wire is_op  = (r >= 8'h30) && (r <= 8'h9F) && slot_ok;
  wire is_flo = (r[7:2] == 6'b101000) && slot_ok;
  wire is_fhi = (r[7:2] == 6'b101001) && slot_ok;
  wire is_alg = (r[7:2] == 6'b101100) && slot_ok;
  wire is_tah = (r == 8'h24);
  wire is_tal = (r == 8'h25);
  wire is_tb  = (r == 8'h26);
  wire is_key = (r == 8'h28);
  wire is_dd  = (r == 8'h2A);
  wire is_dc  = (r == 8'h2B);
  wire known  = is_op | is_flo | is_fhi | is_alg | is_tah | is_tal |
                is_tb | is_key | is_dd | is_dc;

  assign rd_data = {6'b0, timer_a_ovf, timer_b_ovf};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q[0]   <= '0;
      sel_q[1]   <= '0;
      for (int i = 0; i < NV; i++) stage_q[i] <= '0;
      op_wr      <= 1'b0;
      op_voice   <= '0;
      op_slot    <= '0;
      op_field   <= '0;
      op_value   <= '0;
      op_mul_x2  <= '0;
      op_att_qdb <= '0;
      tmr_a_wr   <= 1'b0;
      tmr_a_load <= '0;
      tmr_b_wr   <= 1'b0;
      tmr_b_load <= '0;
      key_wr     <= 1'b0;
      key_voice  <= '0;
      key_mask   <= '0;
      dac_en     <= 1'b0;
      dac_wr     <= 1'b0;
      dac_sample <= '0;
      frq_wr     <= 1'b0;
      frq_voice  <= '0;
      frq_num    <= '0;
      frq_block  <= '0;
      alg_wr     <= 1'b0;
      alg_voice  <= '0;
      alg_sel    <= '0;
      unhandled  <= 1'b0;
    end else begin
      op_wr     <= 1'b0;
      tmr_a_wr  <= 1'b0;
      tmr_b_wr  <= 1'b0;
      key_wr    <= 1'b0;
      dac_wr    <= 1'b0;
      frq_wr    <= 1'b0;
      alg_wr    <= 1'b0;
      unhandled <= go && !known;
      if (bus_we && !bus_addr[0]) sel_q[bank] <= d;
      if (go) begin
        if (is_op) begin
          op_wr      <= 1'b1;
          op_voice   <= voice;
          op_slot    <= r[3:2];
          op_field   <= r[6:4] - 3'd3;
          op_value   <= d;
          op_mul_x2  <= (d[3:0] == 4'd0) ? 5'd1 : {d[3:0], 1'b0};
          op_att_qdb <= {2'b0, d[6:0]} + {1'b0, d[6:0], 1'b0};
        end
        if (is_tah) begin
          tmr_a_load[9:2] <= d;
          tmr_a_wr        <= 1'b1;
        end
        if (is_tal) begin
          tmr_a_load[1:0] <= d[1:0];
          tmr_a_wr        <= 1'b1;
        end
        if (is_tb) begin
          tmr_b_load <= d;
          tmr_b_wr   <= 1'b1;
        end
        if (is_key) begin
          key_wr    <= 1'b1;
          key_voice <= d[2:0];
          key_mask  <= d[7:4];
        end
        if (is_dc) dac_en <= d[7];
        if (is_dd && dac_en) begin
          dac_wr     <= 1'b1;
          dac_sample <= d;
        end
        if (is_fhi) stage_q[voice] <= d[5:0];
        if (is_flo) begin
          frq_wr    <= 1'b1;
          frq_voice <= voice;
          frq_num   <= {stage_q[voice][2:0], d};
          frq_block <= stage_q[voice][5:3];
        end
        if (is_alg) begin
          alg_wr    <= 1'b1;
          alg_voice <= voice;
          alg_sel   <= d[2:0];
        end
      end
    end
  end

  // R13
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_wr, tmr_a_wr, tmr_b_wr, key_wr, dac_wr, frq_wr, alg_wr, unhandled}));

  // R13
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|{op_wr, tmr_a_wr, tmr_b_wr, key_wr, dac_wr, frq_wr, alg_wr, unhandled})
      |-> $past(bus_we && bus_addr[0]));

  // R8
  dac_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_wr |-> $past(dac_en));

  // R12
  unh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unhandled |-> ($stable(tmr_a_load) && $stable(tmr_b_load) && $stable(dac_en)));

  // R6
  tmra_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_a_wr |-> $stable(tmr_a_load));

  // R2
  op_voice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_wr |-> (op_voice < 3'(NV)));
endmodule

// File: tb/test_fm_regport.sv
module test_fm_regport;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic timer_a_ovf = 1'b0;
  logic timer_b_ovf = 1'b0;
  logic [7:0] rd_data;
  logic op_wr, tmr_a_wr, tmr_b_wr, key_wr, dac_en, dac_wr, frq_wr, alg_wr, unhandled;
  logic [2:0] op_voice, op_field, key_voice, frq_voice, frq_block, alg_voice, alg_sel;
  logic [1:0] op_slot;
  logic [7:0] op_value, tmr_b_load, dac_sample;
  logic [4:0] op_mul_x2;
  logic [8:0] op_att_qdb;
  logic [9:0] tmr_a_load;
  logic [3:0] key_mask;
  logic [10:0] frq_num;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fm_regport i_fm_regport (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .timer_a_ovf(timer_a_ovf),
    .timer_b_ovf(timer_b_ovf), .op_wr(op_wr), .op_voice(op_voice),
    .op_slot(op_slot), .op_field(op_field), .op_value(op_value),
    .op_mul_x2(op_mul_x2), .op_att_qdb(op_att_qdb), .tmr_a_wr(tmr_a_wr),
    .tmr_a_load(tmr_a_load), .tmr_b_wr(tmr_b_wr), .tmr_b_load(tmr_b_load),
    .key_wr(key_wr), .key_voice(key_voice), .key_mask(key_mask),
    .dac_en(dac_en), .dac_wr(dac_wr), .dac_sample(dac_sample),
    .frq_wr(frq_wr), .frq_voice(frq_voice), .frq_num(frq_num),
    .frq_block(frq_block), .alg_wr(alg_wr), .alg_voice(alg_voice),
    .alg_sel(alg_sel), .unhandled(unhandled)
  );

  function automatic logic [7:0] strobes();
    return {op_wr, tmr_a_wr, tmr_b_wr, key_wr, dac_wr, frq_wr, alg_wr, unhandled};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic reg_wr(input logic b, input logic [7:0] rg, input logic [7:0] v);
    wr({b, 1'b0}, rg);
    wr({b, 1'b1}, v);
  endtask

  task automatic pulse_gone(input string req);
    @(negedge clk);
    chk(req, {24'b0, strobes()}, 32'h0);
  endtask

  task automatic t_reset;
    chk("R1 reset strobes", {24'b0, strobes()}, 32'h0);
    chk("R8 reset dac_en", {31'b0, dac_en}, 32'h0);
    chk("R6 reset tmr_a_load", {22'b0, tmr_a_load}, 32'h0);
    wr(2'd1, 8'h55);
    chk("R1 write with no selection", {24'b0, strobes()}, 32'h0);
    wr(2'd3, 8'h55);
    chk("R1 bank1 write with no selection", {24'b0, strobes()}, 32'h0);
  endtask

  task automatic t_banks;
    wr(2'd0, 8'h28);
    wr(2'd2, 8'h30);
    wr(2'd1, 8'hF2);
    chk("R7 key_wr", {31'b0, key_wr}, 32'h1);
    chk("R7 key_voice", {29'b0, key_voice}, 32'h2);
    chk("R7 key_mask", {28'b0, key_mask}, 32'hF);
    pulse_gone("R13 key pulse ends");
    wr(2'd3, 8'h05);
    chk("R1 bank1 uses own selection", {31'b0, op_wr}, 32'h1);
    chk("R2 bank1 voice", {29'b0, op_voice}, 32'h3);
    chk("R2 field 0x3x", {29'b0, op_field}, 32'h0);
    chk("R4 multiplier 5", {27'b0, op_mul_x2}, 32'd10);
    wr(2'd1, 8'h51);
    chk("R7 bank0 selection kept", {28'b0, key_mask, 1'b0, key_voice}, 32'h51);
  endtask

  task automatic t_operator;
    reg_wr(1'b0, 8'h4D, 8'hFF);
    chk("R2 op_wr", {31'b0, op_wr}, 32'h1);
    chk("R2 voice", {29'b0, op_voice}, 32'h1);
    chk("R2 slot", {30'b0, op_slot}, 32'h3);
    chk("R2 field 0x4x", {29'b0, op_field}, 32'h1);
    chk("R2 value", {24'b0, op_value}, 32'hFF);
    chk("R5 attenuation bit7 ignored", {23'b0, op_att_qdb}, 32'd381);
    reg_wr(1'b0, 8'h40, 8'h05);
    chk("R5 attenuation 5", {23'b0, op_att_qdb}, 32'd15);
    reg_wr(1'b1, 8'h9E, 8'h00);
    chk("R2 bank1 slot3 voice", {29'b0, op_voice}, 32'h5);
    chk("R2 field 0x9x", {29'b0, op_field}, 32'h6);
    chk("R4 multiplier zero is half", {27'b0, op_mul_x2}, 32'd1);
    reg_wr(1'b0, 8'h30, 8'hF3);
    chk("R4 multiplier upper nibble ignored", {27'b0, op_mul_x2}, 32'd6);
    wr(2'd1, 8'h0F);
    chk("R4 multiplier 15", {27'b0, op_mul_x2}, 32'd30);
  endtask

  task automatic t_badslot;
    reg_wr(1'b0, 8'h33, 8'h11);
    chk("R3 slot 3 no op_wr", {31'b0, op_wr}, 32'h0);
    chk("R3 slot 3 unhandled", {31'b0, unhandled}, 32'h1);
    pulse_gone("R13 unhandled pulse ends");
    reg_wr(1'b1, 8'h8F, 8'h11);
    chk("R3 bank1 slot 3 unhandled", {24'b0, strobes()}, 32'h1);
  endtask

  task automatic t_timer;
    reg_wr(1'b0, 8'h24, 8'hAB);
    chk("R6 timer A strobe", {31'b0, tmr_a_wr}, 32'h1);
    reg_wr(1'b0, 8'h25, 8'hFF);
    chk("R6 timer A assembled", {22'b0, tmr_a_load}, 32'h2AF);
    reg_wr(1'b1, 8'h26, 8'h5A);
    chk("R6 timer B", {24'b0, tmr_b_load}, 32'h5A);
    chk("R6 timer B strobe", {31'b0, tmr_b_wr}, 32'h1);
    reg_wr(1'b0, 8'h24, 8'h00);
    chk("R6 timer A low bits kept", {22'b0, tmr_a_load}, 32'h003);
    pulse_gone("R13 timer pulse ends");
    chk("R6 timer A holds", {22'b0, tmr_a_load}, 32'h003);
  endtask

  task automatic t_dac;
    reg_wr(1'b0, 8'h2A, 8'h80);
    chk("R8 sample dropped when disabled", {24'b0, strobes()}, 32'h0);
    reg_wr(1'b0, 8'h2B, 8'h80);
    chk("R8 dac_en set", {31'b0, dac_en}, 32'h1);
    reg_wr(1'b0, 8'h2A, 8'h37);
    chk("R8 dac_wr", {31'b0, dac_wr}, 32'h1);
    chk("R8 dac_sample", {24'b0, dac_sample}, 32'h37);
    reg_wr(1'b0, 8'h2B, 8'h7F);
    chk("R8 dac_en cleared", {31'b0, dac_en}, 32'h0);
  endtask

  task automatic t_freq;
    reg_wr(1'b0, 8'hA5, 8'h2B);
    chk("R9 high write no strobe", {24'b0, strobes()}, 32'h0);
    reg_wr(1'b0, 8'hA1, 8'hC4);
    chk("R9 frq_wr", {31'b0, frq_wr}, 32'h1);
    chk("R9 frq_voice", {29'b0, frq_voice}, 32'h1);
    chk("R9 frq_num", {21'b0, frq_num}, 32'h3C4);
    chk("R9 frq_block", {29'b0, frq_block}, 32'h5);
    reg_wr(1'b1, 8'hA6, 8'h3F);
    reg_wr(1'b1, 8'hA2, 8'h01);
    chk("R9 bank1 voice", {29'b0, frq_voice}, 32'h5);
    chk("R9 bank1 num", {21'b0, frq_num}, 32'h701);
    chk("R9 bank1 block", {29'b0, frq_block}, 32'h7);
    reg_wr(1'b0, 8'hA1, 8'h10);
    chk("R9 staged bits persist", {18'b0, frq_block, frq_num}, {18'b0, 3'd5, 11'h310});
    reg_wr(1'b0, 8'hA0, 8'hEE);
    chk("R9 other voice unstaged", {18'b0, frq_block, frq_num}, {18'b0, 3'd0, 11'h0EE});
  endtask

  task automatic t_alg;
    reg_wr(1'b1, 8'hB1, 8'hFE);
    chk("R10 alg_wr", {31'b0, alg_wr}, 32'h1);
    chk("R10 alg_voice", {29'b0, alg_voice}, 32'h4);
    chk("R10 alg_sel", {29'b0, alg_sel}, 32'h6);
  endtask

  task automatic t_unhandled;
    reg_wr(1'b0, 8'h27, 8'h15);
    chk("R12 0x27 unhandled", {24'b0, strobes()}, 32'h1);
    chk("R12 timer A unchanged", {22'b0, tmr_a_load}, 32'h003);
    chk("R12 timer B unchanged", {24'b0, tmr_b_load}, 32'h5A);
    reg_wr(1'b0, 8'h10, 8'h80);
    chk("R12 low register unhandled", {31'b0, unhandled}, 32'h1);
    chk("R12 dac_en unchanged", {31'b0, dac_en}, 32'h0);
    reg_wr(1'b0, 8'hA7, 8'h3F);
    chk("R12 0xA7 unhandled", {31'b0, unhandled}, 32'h1);
    reg_wr(1'b0, 8'hA3, 8'h3F);
    chk("R12 0xA3 unhandled", {31'b0, unhandled}, 32'h1);
    reg_wr(1'b0, 8'hB3, 8'h01);
    chk("R12 0xB3 unhandled", {24'b0, strobes()}, 32'h1);
    reg_wr(1'b0, 8'hA1, 8'h00);
    chk("R12 staging untouched", {18'b0, frq_block, frq_num}, {18'b0, 3'd5, 11'h300});
    pulse_gone("R13 single cycle");
  endtask

  task automatic t_status;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      bus_addr = 2'(i);
      timer_a_ovf = i[0];
      timer_b_ovf = i[1];
      #1;
      chk("R11 status", {24'b0, rd_data}, {30'b0, i[0], i[1]});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL R13 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_banks();
    t_operator();
    t_badslot();
    t_timer();
    t_dac();
    t_freq();
    t_alg();
    t_unhandled();
    t_status();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule